// File: doc/BRIEF.md
# Bus-to-Kernel Register Write Bridge

This block joins a register port on an APB-style bus to a peripheral core that runs on its own kernel clock. The two clocks are unrelated. Each writable register has a holding copy in the bus domain and a shadow copy in the kernel domain. Every bus write crosses to the shadow through a toggle request/acknowledge handshake. Because of that handshake, the core sees a new value a few kernel cycles after the bus transfer ends.

A write normally ends with no wait states. A write only stalls when it targets a register whose previous write is still crossing. In that case the transfer holds PREADY low until the earlier crossing has been acknowledged, and then it completes. Each register has its own handshake and busy flag, so writes to different registers never hold each other up. Reads return the bus-side holding copy at once.

The bus-side phase tracker is a small state machine. `ST_IDLE` means no transfer was seen. `ST_SETUP` means a setup phase was seen. `ST_WAIT` means an access phase was held by a busy register. `ST_DONE` means an access phase completed. From any state, the tracker moves as follows:
- To `ST_IDLE` when the select is low.
- To `ST_SETUP` when the select is high and the enable is low.
- To `ST_DONE` when select, enable and ready are all high.
- To `ST_WAIT` when select and enable are high and ready is low.

A write is committed only in an access cycle whose previous state was `ST_SETUP` or `ST_WAIT`.

Top module: `regxing_bridge`

## Requirements
- R1: After both resets, every shadow and every holding register equals the parameter `RST_VAL`. `kreg_upd` is zero, and no register is busy.
- R2: Every committed write to a mapped register reaches that register's kernel shadow exactly once and in commit order. The shadow slice for register i is `kreg_q[i*DATA_W +: DATA_W]`. Each arrival is marked by a one-kernel-cycle pulse on `kreg_upd[i]`. This holds for kernel clocks both faster and slower than the bus clock, including ratios from 1.5 to 3.
- R3: A write to a register with no earlier write still crossing completes with PREADY high in its first access cycle.
- R4: A write to a register whose previous write has not been acknowledged is held with PREADY low. It completes once the crossing is done, and its value then reaches the kernel.
- R5: A read never inserts a wait state.
- R6: The wait states of a stalled write never last longer than 2 bus clock periods plus 6 kernel clock periods.
- R7: A write to one register never waits because another register is busy.
- R8: A read of register i returns the value of the most recent write to i as soon as that write has completed, before the kernel has taken it.
- R9: A kernel shadow changes only in the cycle where its `kreg_upd` bit pulses.
- R10: `paddr` selects register i when it equals i. An address at or above `NUM_REGS` is unmapped. A write there completes without wait states and changes no register, and a read there returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Bus-domain asynchronous reset, active low |
| psel | input | 1 | Transfer select |
| penable | input | 1 | Access-phase enable |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | ADDR_W | Register index |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data (holding copy) |
| pready | output | 1 | Low while a write is held |
| kclk | input | 1 | Kernel clock |
| kresetn | input | 1 | Kernel-domain asynchronous reset, active low |
| kreg_q | output | NUM_REGS*DATA_W | Kernel shadow registers, register i at bits i*DATA_W upward |
| kreg_upd | output | NUM_REGS | One-cycle pulse per register when its shadow loads |

## Verification
The bench runs the same traffic at kernel periods of 7.5, 10, 15, 3 and 40 ns against a 5 ns bus clock.
- Back-to-back writes to one register show whether the stall is raised when it must be and released within the bound.
- A write to a second register right after the first shows that busy flags do not leak across registers.
- Reads right after writes tell the bus-side copy apart from the kernel copy.
- Writes to an unmapped index expose aliasing onto a real register.

A per-register queue model checks every kernel-clock sample for arrival order, duplicates and unannounced changes.

// File: rtl/regxing_pkg.sv
`timescale 1ns/1ps
package regxing_pkg;

    // Phase seen on the bus in the previous cycle
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } bus_state_t;

endpackage

// File: rtl/regxing_sync2.sv
`timescale 1ns/1ps
module regxing_sync2 #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            q      <= '0;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end

endmodule

// File: rtl/regxing_bus_slot.sv
`timescale 1ns/1ps
module regxing_bus_slot #(
    parameter int                DATA_W  = 32,
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ack_tgl,
    output logic [DATA_W-1:0] hold,
    output logic              req_tgl,
    output logic              busy
);

    logic ack_s;

    regxing_sync2 #(.W(1)) u_ack_sync (
        .clk   (pclk),
        .rst_n (presetn),
        .d     (ack_tgl),
        .q     (ack_s)
    );

    // Data is only changed while no crossing is pending, so it stays stable
    // for the kernel side while the request is in flight.
    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            hold    <= RST_VAL;
            req_tgl <= 1'b0;
        end else if (wr_en) begin
            hold    <= wdata;
            req_tgl <= ~req_tgl;
        end
    end

    assign busy = req_tgl ^ ack_s;

endmodule

// File: rtl/regxing_kern_slot.sv
`timescale 1ns/1ps
module regxing_kern_slot #(
    parameter int                DATA_W  = 32,
    parameter logic [DATA_W-1:0] RST_VAL = '0
) (
    input  logic              kclk,
    input  logic              kresetn,
    input  logic              req_tgl,
    input  logic [DATA_W-1:0] hold,
    output logic [DATA_W-1:0] shadow,
    output logic              ack_tgl,
    output logic              upd
);

    logic req_s;

    regxing_sync2 #(.W(1)) u_req_sync (
        .clk   (kclk),
        .rst_n (kresetn),
        .d     (req_tgl),
        .q     (req_s)
    );

    // A new request is a synchronized toggle differing from the last ack.
    always_ff @(posedge kclk or negedge kresetn) begin
        if (!kresetn) begin
            shadow  <= RST_VAL;
            ack_tgl <= 1'b0;
            upd     <= 1'b0;
        end else if (req_s != ack_tgl) begin
            shadow  <= hold;
            ack_tgl <= req_s;
            upd     <= 1'b1;
        end else begin
            upd     <= 1'b0;
        end
    end

endmodule

// File: rtl/regxing_bridge.sv
`timescale 1ns/1ps
module regxing_bridge
    import regxing_pkg::*;
#(
    parameter int                NUM_REGS = 4,
    parameter int                DATA_W   = 32,
    parameter int                ADDR_W   = 3,
    parameter logic [DATA_W-1:0] RST_VAL  = '0
) (
    input  logic                         pclk,
    input  logic                         presetn,
    input  logic                         psel,
    input  logic                         penable,
    input  logic                         pwrite,
    input  logic [ADDR_W-1:0]            paddr,
    input  logic [DATA_W-1:0]            pwdata,
    output logic [DATA_W-1:0]            prdata,
    output logic                         pready,
    input  logic                         kclk,
    input  logic                         kresetn,
    output logic [NUM_REGS*DATA_W-1:0]   kreg_q,
    output logic [NUM_REGS-1:0]          kreg_upd
);

    localparam int FLAT_W = NUM_REGS * DATA_W;

    bus_state_t state_q, state_d;

    logic [NUM_REGS-1:0] sel_vec;
    logic [NUM_REGS-1:0] busy_vec;
    logic [NUM_REGS-1:0] commit_vec;
    logic [NUM_REGS-1:0] req_vec;
    logic [NUM_REGS-1:0] ack_vec;
    logic [DATA_W-1:0]   hold_arr   [NUM_REGS];
    logic [DATA_W-1:0]   shadow_arr [NUM_REGS];
    logic                busy_sel;
    logic                access_ok;
    logic                wr_access;

    // ---------------- address decode ----------------
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
        assign sel_vec[i] = (paddr == ADDR_W'(i));
    end

    assign busy_sel  = |(busy_vec & sel_vec);
    assign wr_access = psel && penable && pwrite;

    // ---------------- phase tracker: state register ----------------
    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) state_q <= ST_IDLE;
        else          state_q <= state_d;
    end

    always_comb begin
        state_d = ST_IDLE;
        if (psel) begin
            if (!penable)    state_d = ST_SETUP;
            else if (pready) state_d = ST_DONE;
            else             state_d = ST_WAIT;
        end
    end

    // ---------------- phase tracker: outputs ----------------
    always_comb begin
        unique case (state_q)
            ST_SETUP, ST_WAIT: access_ok = 1'b1;
            ST_IDLE,  ST_DONE: access_ok = 1'b0;
            default:           access_ok = 1'b0;
        endcase
        pready     = !(wr_access && busy_sel);
        commit_vec = (wr_access && access_ok && !busy_sel) ? sel_vec : '0;
    end

    // ---------------- read mux (one-hot select) ----------------
    always_comb begin
        prdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (sel_vec[i]) prdata = hold_arr[i];
        end
    end

    // ---------------- per-register crossings ----------------
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        regxing_bus_slot #(
            .DATA_W  (DATA_W),
            .RST_VAL (RST_VAL)
        ) u_bus (
            .pclk    (pclk),
            .presetn (presetn),
            .wr_en   (commit_vec[i]),
            .wdata   (pwdata),
            .ack_tgl (ack_vec[i]),
            .hold    (hold_arr[i]),
            .req_tgl (req_vec[i]),
            .busy    (busy_vec[i])
        );

        regxing_kern_slot #(
            .DATA_W  (DATA_W),
            .RST_VAL (RST_VAL)
        ) u_kern (
            .kclk    (kclk),
            .kresetn (kresetn),
            .req_tgl (req_vec[i]),
            .hold    (hold_arr[i]),
            .shadow  (shadow_arr[i]),
            .ack_tgl (ack_vec[i]),
            .upd     (kreg_upd[i])
        );

        assign kreg_q[i*DATA_W +: DATA_W] = shadow_arr[i];
    end

    if (FLAT_W < DATA_W) begin : g_never
        initial $display("regxing_bridge: NUM_REGS must be at least 1");
    end

endmodule

// File: rtl/regxing_bridge_chk.sv
`timescale 1ns/1ps
module regxing_bridge_chk #(
    parameter int NUM_REGS      = 4,
    parameter int MAX_STALL_CYC = 64
) (
    input logic                pclk,
    input logic                presetn,
    input logic                psel,
    input logic                penable,
    input logic                pwrite,
    input logic                pready,
    input logic [NUM_REGS-1:0] sel_vec,
    input logic [NUM_REGS-1:0] busy_vec,
    input logic [NUM_REGS-1:0] commit_vec,
    input logic                kclk,
    input logic                kresetn,
    input logic [NUM_REGS-1:0] kreg_upd
);

    int unsigned stall_cnt;

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn)                          stall_cnt <= 0;
        else if (psel && penable && !pready)   stall_cnt <= stall_cnt + 1;
        else                                   stall_cnt <= 0;
    end

    // R1: nothing is in flight right after the bus reset releases
    a_r1_idle_after_reset: assert property (@(posedge pclk) disable iff (!presetn)
        $rose(presetn) |-> (busy_vec == '0));

    // R5: reads complete without wait
    a_r5_read_no_wait: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && !pwrite) |-> pready);

    // R4 / R7: a wait only occurs on a write to a register that is busy
    a_r4_stall_needs_pending: assert property (@(posedge pclk) disable iff (!presetn)
        (psel && penable && !pready) |-> (pwrite && ((busy_vec & sel_vec) != '0)));

    // R2: a committed write leaves its register in flight
    a_r2_commit_sets_busy: assert property (@(posedge pclk) disable iff (!presetn)
        (commit_vec != '0) |=> ((busy_vec & $past(commit_vec)) == $past(commit_vec)));

    // R6: a stall never runs away
    a_r6_stall_bounded: assert property (@(posedge pclk) disable iff (!presetn)
        stall_cnt <= MAX_STALL_CYC);

    // R2 / R9: each arrival is a single-cycle pulse
    a_r9_single_pulse: assert property (@(posedge kclk) disable iff (!kresetn)
        (kreg_upd != '0) |=> ((kreg_upd & $past(kreg_upd)) == '0));

endmodule

bind regxing_bridge regxing_bridge_chk #(
    .NUM_REGS (NUM_REGS)
) u_chk (
    .pclk       (pclk),
    .presetn    (presetn),
    .psel       (psel),
    .penable    (penable),
    .pwrite     (pwrite),
    .pready     (pready),
    .sel_vec    (sel_vec),
    .busy_vec   (busy_vec),
    .commit_vec (commit_vec),
    .kclk       (kclk),
    .kresetn    (kresetn),
    .kreg_upd   (kreg_upd)
);

// File: tb/regxing_bridge_tb.sv
`timescale 1ns/1ps
module regxing_bridge_tb;

    localparam int          NR   = 4;
    localparam int          DW   = 32;
    localparam int          AW   = 3;
    localparam logic [31:0] RSTV = 32'h0000_A5A5;
    localparam real         TP   = 5.0;

    logic pclk = 1'b0;
    logic kclk = 1'b0;
    real  kper = 7.5;

    always #2.5 pclk = ~pclk;
    always #(kper / 2.0) kclk = ~kclk;

    logic              presetn, kresetn;
    logic              psel, penable, pwrite;
    logic [AW-1:0]     paddr;
    logic [DW-1:0]     pwdata, prdata;
    logic              pready;
    logic [NR*DW-1:0]  kreg_q;
    logic [NR-1:0]     kreg_upd;

    regxing_bridge #(
        .NUM_REGS (NR),
        .DATA_W   (DW),
        .ADDR_W   (AW),
        .RST_VAL  (RSTV)
    ) u_dut (
        .pclk     (pclk),
        .presetn  (presetn),
        .psel     (psel),
        .penable  (penable),
        .pwrite   (pwrite),
        .paddr    (paddr),
        .pwdata   (pwdata),
        .prdata   (prdata),
        .pready   (pready),
        .kclk     (kclk),
        .kresetn  (kresetn),
        .kreg_q   (kreg_q),
        .kreg_upd (kreg_upd)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit kmon_en = 0;

    logic [DW-1:0] expq  [NR][$];
    logic [DW-1:0] lastw [NR];
    logic [DW-1:0] kprev [NR];
    realtime       lastc [NR];

    task automatic chk(input bit ok, input string tag,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $realtime);
        end
    endtask

    // ---------------- kernel-side reference model, every kernel clock ----------------
    always @(negedge kclk) begin
        if (kmon_en) begin
            for (int i = 0; i < NR; i++) begin
                logic [DW-1:0] cur;
                cur = kreg_q[i*DW +: DW];
                if (kreg_upd[i]) begin
                    if (expq[i].size() == 0) begin
                        chk(1'b0, "R2 unexpected arrival", cur, kprev[i]);
                    end else begin
                        logic [DW-1:0] e;
                        e = expq[i].pop_front();
                        chk(cur == e, "R2 arrival order", cur, e);
                    end
                end else begin
                    chk(cur == kprev[i], "R9 shadow moved without pulse", cur, kprev[i]);
                end
                kprev[i] = cur;
            end
        end
    end

    // ---------------- bus tasks ----------------
    task automatic apb_write(input int idx, input logic [DW-1:0] d,
                             input bit b2b, output int waits);
        realtime tacc;
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = AW'(idx); pwdata = d;
        @(negedge pclk);
        penable = 1'b1;
        #1;
        tacc  = $realtime;
        waits = 0;
        while (!pready) begin
            waits++;
            @(negedge pclk);
            #1;
        end
        @(posedge pclk);
        if (idx < NR) begin
            expq[idx].push_back(d);
            lastw[idx] = d;
            // R6: bounded stall
            chk((waits * TP) <= (2.0 * TP + 6.0 * kper), "R6 stall bound",
                DW'(waits), DW'(0));
            // R3: quiet register accepts at once
            if ((tacc - lastc[idx]) > (3.0 * TP + 4.0 * kper))
                chk(waits == 0, "R3 zero-wait write", DW'(waits), DW'(0));
            // R4: back-to-back write to the same register must stall
            if (b2b && (2.0 * kper + TP > 9.0))
                chk(waits > 0, "R4 expected stall", DW'(waits), DW'(1));
            lastc[idx] = $realtime;
        end else begin
            chk(waits == 0, "R10 unmapped write waits", DW'(waits), DW'(0));
        end
    endtask

    task automatic apb_read(input int idx, input string tag,
                            input logic [DW-1:0] exp);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = AW'(idx);
        @(negedge pclk);
        penable = 1'b1;
        #1;
        chk(pready == 1'b1, "R5 read ready", DW'(pready), DW'(1));
        chk(prdata == exp, tag, prdata, exp);
        @(posedge pclk);
    endtask

    task automatic bus_idle();
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic quiesce();
        int left;
        for (int n = 0; n < 400; n++) begin
            left = 0;
            for (int i = 0; i < NR; i++) left += expq[i].size();
            if (left == 0) break;
            @(posedge pclk);
        end
        left = 0;
        for (int i = 0; i < NR; i++) left += expq[i].size();
        chk(left == 0, "R2 all writes delivered", DW'(left), DW'(0));
        repeat (20) @(posedge pclk);
    endtask

    task automatic run_phase(input real kp, input logic [7:0] tag);
        int w;
        kper = kp;
        repeat (10) @(posedge pclk);
        // same register back to back
        apb_write(0, {tag, 24'h000001}, 1'b0, w);
        apb_write(0, {tag, 24'h000002}, 1'b1, w);
        apb_write(0, {tag, 24'h000003}, 1'b1, w);
        // R8: bus copy visible right away
        apb_read(0, "R8 read after write", {tag, 24'h000003});
        bus_idle();
        quiesce();
        // R7: a busy neighbour never stalls another register
        apb_write(1, {tag, 24'h000011}, 1'b0, w);
        apb_write(2, {tag, 24'h000022}, 1'b0, w);
        chk(w == 0, "R7 independent registers", DW'(w), DW'(0));
        apb_write(3, {tag, 24'h000033}, 1'b0, w);
        chk(w == 0, "R7 independent registers", DW'(w), DW'(0));
        // R10: unmapped index
        apb_write(5, {tag, 24'h0000EE}, 1'b0, w);
        apb_read(5, "R10 unmapped read zero", '0);
        apb_read(1, "R10 no alias onto register 1", lastw[1]);
        bus_idle();
        // mixed pattern
        for (int k = 0; k < 12; k++) begin
            int r;
            r = (k * 3) % NR;
            apb_write(r, {tag, 8'h40, 8'(k), 8'(r)}, 1'b0, w);
        end
        for (int i = 0; i < NR; i++) apb_read(i, "R8 readback", lastw[i]);
        bus_idle();
        quiesce();
    endtask

    // ---------------- main sequence ----------------
    initial begin
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0; paddr = '0; pwdata = '0;
        presetn = 1'b0; kresetn = 1'b0;
        for (int i = 0; i < NR; i++) begin
            lastw[i] = RSTV;
            kprev[i] = RSTV;
            lastc[i] = -1.0e9;
        end
        #13 kresetn = 1'b1;
        #9  presetn = 1'b1;
        repeat (4) @(posedge pclk);
        @(negedge pclk);
        // R1: reset state
        for (int i = 0; i < NR; i++)
            chk(kreg_q[i*DW +: DW] == RSTV, "R1 shadow reset value", kreg_q[i*DW +: DW], RSTV);
        chk(kreg_upd == '0, "R1 no pulse after reset", DW'(kreg_upd), '0);
        chk(pready == 1'b1, "R1 ready after reset", DW'(pready), DW'(1));
        for (int i = 0; i < NR; i++) apb_read(i, "R1 holding reset value", RSTV);
        bus_idle();
        kmon_en = 1'b1;

        run_phase(7.5,  8'hA1);   // ratio 1.5
        run_phase(10.0, 8'hB2);   // ratio 2
        run_phase(15.0, 8'hC3);   // ratio 3
        run_phase(3.0,  8'hD4);   // kernel faster
        run_phase(40.0, 8'hE5);   // kernel much slower

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #900000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule